// File: doc/BRIEF.md
# Microcode Next-Address Sequencer

This block picks the next micro-address of a microprogrammed multicycle control unit. It has a 4-bit state register and a control store with one word per state. Each word carries a datapath strobe field and a 2-bit sequencing selector. The selector decides where the sequencer goes next. There are four choices: back to state 0, a jump through one of two opcode-indexed dispatch tables, or the current state plus one.

The opcode input comes from the instruction register. The first dispatch table sends each instruction class to its own micro-routine once decode is done. The second table splits loads from stores after the shared address-calculation step. The current state is also an output, so the sequence can be watched. The datapath itself is not part of this block.

Top module: `useq_dispatch`

## Requirements
- R1: While `rst` is high at a rising edge, the state register loads 0. The first state after reset is 0 (fetch).
- R2: The state register changes only on the rising clock edge. The selector and strobes are a combinational read of the current state. Selector 00 sends the next state to 0. Selector 11 sends it to the current state plus one.
- R3: Selector 01 indexes the first table by opcode. The mappings are: 000000 goes to 6, 000010 goes to 9, 000100 goes to 8, 001011 goes to 10, and both 100011 and 101011 go to 2.
- R4: Selector 10 indexes the second table by opcode. 100011 goes to 3 and 101011 goes to 5.
- R5: An opcode that has no entry in the table being indexed sends the next state to 0. This holds for both tables.
- R6: `addr_ctl` by state is: 0:11, 1:01, 2:10, 3:11, 4:00, 5:00, 6:11, 7:00, 8:00, 9:00, 10:11, 11:00.
- R7: In `strobes`, bit 0 is PC write, bit 1 is instruction-register write, bit 2 is memory write and bit 3 is register-file write. PC write is high only in states 0 and 9. Instruction-register write is high only in state 0. Memory write is high only in state 5. Register-file write is high only in states 4, 7 and 11.
- R8: With the opcode held, the full visit order starting from state 0 is as follows. Opcode 100011 runs 0,1,2,3,4 and 101011 runs 0,1,2,5. Opcode 000000 runs 0,1,6,7, 000100 runs 0,1,8, 000010 runs 0,1,9, and 001011 runs 0,1,10,11. Each run then returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the current instruction |
| upc | output | 4 | Current micro-address (state number) |
| strobes | output | 17 | Datapath strobe field of the current control word |
| addr_ctl | output | 2 | Sequencing selector of the current control word |

## Verification
The state register is the only storage in the block. `upc` therefore moves one clock edge after the opcode and selector that decide it. `strobes` and `addr_ctl` follow `upc` in the same cycle with no register in between. The bench changes the opcode on falling edges and reads all outputs on the falling edge after each rising edge. Each step of a visit order is compared against the state expected for exactly that edge. The selector and strobe checks are made against the state seen in that same sample.

// File: rtl/useq_dispatch.sv
module useq_dispatch #(
  parameter int OPC_W = 6,
  parameter int ST_W  = 4,
  parameter int STB_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output logic [ST_W-1:0]  upc,
  output logic [STB_W-1:0] strobes,
  output logic [1:0]       addr_ctl
);
  localparam int CW_W = STB_W + 2;
  localparam logic [1:0] SEL_ZERO = 2'b00, SEL_TAB1 = 2'b01,
                         SEL_TAB2 = 2'b10, SEL_INC  = 2'b11;
  localparam logic [1:0] ALU_ADD = 2'b00, ALU_SUB = 2'b01,
                         ALU_FN  = 2'b10, ALU_OR  = 2'b11;

  function automatic logic [ST_W-1:0] tab1(input logic [OPC_W-1:0] op);
    case (op)
      OPC_W'(6'b000000): tab1 = ST_W'(6);
      OPC_W'(6'b000010): tab1 = ST_W'(9);
      OPC_W'(6'b000100): tab1 = ST_W'(8);
      OPC_W'(6'b001011): tab1 = ST_W'(10);
      OPC_W'(6'b100011),
      OPC_W'(6'b101011): tab1 = ST_W'(2);
      default:           tab1 = '0;
    endcase
  endfunction

  function automatic logic [ST_W-1:0] tab2(input logic [OPC_W-1:0] op);
    case (op)
      OPC_W'(6'b100011): tab2 = ST_W'(3);
      OPC_W'(6'b101011): tab2 = ST_W'(5);
      default:           tab2 = '0;
    endcase
  endfunction

  // strobe bits: 0 pc_wr, 1 ir_wr, 2 mem_wr, 3 reg_wr, 4 pc_wr_cond, 5 br_wr,
  // 6 addr_from_alu, 7 dst_rd, 8 wb_from_mem, 9 a_from_reg, 11:10 b_sel,
  // 13:12 alu_op, 14 sign_ext, 16:15 pc_src
  function automatic logic [CW_W-1:0] cstore(input logic [ST_W-1:0] st);
    logic [STB_W-1:0] s;
    logic [1:0]       q;
    s = '0;
    q = SEL_ZERO;
    case (st)
      ST_W'(0):  begin s[0] = 1'b1; s[1] = 1'b1; s[11:10] = 2'b00;
                       s[13:12] = ALU_ADD; q = SEL_INC; end
      ST_W'(1):  begin s[5] = 1'b1; s[14] = 1'b1; s[11:10] = 2'b10;
                       s[13:12] = ALU_ADD; q = SEL_TAB1; end
      ST_W'(2):  begin s[9] = 1'b1; s[14] = 1'b1; s[11:10] = 2'b11;
                       s[13:12] = ALU_ADD; q = SEL_TAB2; end
      ST_W'(3):  begin s[6] = 1'b1; s[9] = 1'b1; s[14] = 1'b1; s[11:10] = 2'b11;
                       s[13:12] = ALU_ADD; q = SEL_INC; end
      ST_W'(4):  begin s[3] = 1'b1; s[8] = 1'b1; s[6] = 1'b1; s[9] = 1'b1;
                       s[14] = 1'b1; s[11:10] = 2'b11; q = SEL_ZERO; end
      ST_W'(5):  begin s[2] = 1'b1; s[6] = 1'b1; s[9] = 1'b1; s[14] = 1'b1;
                       s[11:10] = 2'b11; q = SEL_ZERO; end
      ST_W'(6):  begin s[7] = 1'b1; s[9] = 1'b1; s[11:10] = 2'b01;
                       s[13:12] = ALU_FN; q = SEL_INC; end
      ST_W'(7):  begin s[3] = 1'b1; s[7] = 1'b1; s[9] = 1'b1; s[11:10] = 2'b01;
                       s[13:12] = ALU_FN; q = SEL_ZERO; end
      ST_W'(8):  begin s[4] = 1'b1; s[9] = 1'b1; s[11:10] = 2'b01;
                       s[13:12] = ALU_SUB; s[16:15] = 2'b01; q = SEL_ZERO; end
      ST_W'(9):  begin s[0] = 1'b1; s[16:15] = 2'b10; q = SEL_ZERO; end
      ST_W'(10): begin s[9] = 1'b1; s[11:10] = 2'b11; s[13:12] = ALU_OR;
                       q = SEL_INC; end
      ST_W'(11): begin s[3] = 1'b1; s[9] = 1'b1; s[11:10] = 2'b11;
                       s[13:12] = ALU_OR; q = SEL_ZERO; end
      default:   begin s = '0; q = SEL_ZERO; end
    endcase
    cstore = {s, q};
  endfunction

  logic [CW_W-1:0] cword;
  logic [ST_W-1:0] nxt;

  assign cword    = cstore(upc);
  assign strobes  = cword[CW_W-1:2];
  assign addr_ctl = cword[1:0];

  always_comb begin
    case (addr_ctl)
      SEL_TAB1: nxt = tab1(opcode);
      SEL_TAB2: nxt = tab2(opcode);
      SEL_INC:  nxt = upc + ST_W'(1);
      default:  nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) upc <= '0;
    else     upc <= nxt;
  end

  a_r1_reset_zero: assert property (@(posedge clk) rst |=> upc == '0);

  a_r2_inc_step: assert property (@(posedge clk) disable iff (rst)
    addr_ctl == SEL_INC |=> upc == $past(upc) + ST_W'(1));

  a_r2_zero_step: assert property (@(posedge clk) disable iff (rst)
    addr_ctl == SEL_ZERO |=> upc == '0);

  a_r4_tab2_range: assert property (@(posedge clk) disable iff (rst)
    addr_ctl == SEL_TAB2 |=> (upc == ST_W'(3) || upc == ST_W'(5) || upc == '0));

  a_r3_tab1_range: assert property (@(posedge clk) disable iff (rst)
    addr_ctl == SEL_TAB1 |=> (upc == '0 || upc == ST_W'(2) || upc == ST_W'(6) ||
                              upc == ST_W'(8) || upc == ST_W'(9) || upc == ST_W'(10)));

  a_r7_mem_wr_store_only: assert property (@(posedge clk) disable iff (rst)
    strobes[2] |-> upc == ST_W'(5));
endmodule

// File: tb/test_useq_dispatch.sv
module test_useq_dispatch;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'b000000;
  logic [3:0] upc;
  logic [16:0] strobes;
  logic [1:0] addr_ctl;
  int n_run = 0;
  int n_fail = 0;

  useq_dispatch i_useq_dispatch (
    .clk(clk), .rst(rst), .opcode(opcode),
    .upc(upc), .strobes(strobes), .addr_ctl(addr_ctl)
  );

  always #10 clk = ~clk;

  function automatic logic [1:0] exp_sel(input int s);
    case (s)
      0, 3, 6, 10: exp_sel = 2'b11;
      1:           exp_sel = 2'b01;
      2:           exp_sel = 2'b10;
      default:     exp_sel = 2'b00;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R6 and R7 checked on whatever state is currently shown
  task automatic chk_word();
    int s;
    s = int'(upc);
    chk("R6 addr_ctl", int'(addr_ctl), int'(exp_sel(s)));
    chk("R7 pc_wr", int'(strobes[0]), (s == 0 || s == 9) ? 1 : 0);
    chk("R7 ir_wr", int'(strobes[1]), (s == 0) ? 1 : 0);
    chk("R7 mem_wr", int'(strobes[2]), (s == 5) ? 1 : 0);
    chk("R7 reg_wr", int'(strobes[3]), (s == 4 || s == 7 || s == 11) ? 1 : 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset state", int'(upc), 0);
    chk_word();
    rst = 1'b0;
  endtask

  task automatic t_seq(input string req, input logic [5:0] op, input int len,
                       input int e0, input int e1, input int e2,
                       input int e3, input int e4, input int e5);
    int exp[6];
    exp = '{e0, e1, e2, e3, e4, e5};
    opcode = op;
    do_reset();
    chk(req, int'(upc), exp[0]);
    chk_word();
    for (int k = 1; k < len; k++) begin
      @(negedge clk);
      chk(req, int'(upc), exp[k]);
      chk_word();
    end
  endtask

  task automatic t_tab2_miss();
    opcode = 6'b100011;
    do_reset();
    repeat (2) @(negedge clk);
    chk("R4 load reached split", int'(upc), 2);
    opcode = 6'b000000;
    @(negedge clk);
    chk("R5 tab2 miss", int'(upc), 0);
  endtask

  task automatic t_live_opcode();
    opcode = 6'b000000;
    do_reset();
    opcode = 6'b101011;
    @(negedge clk);
    chk("R3 late opcode", int'(upc), 1);
    @(negedge clk);
    chk("R3 store via tab1", int'(upc), 2);
    @(negedge clk);
    chk("R4 store via tab2", int'(upc), 5);
  endtask

  task automatic t_mid_reset();
    opcode = 6'b001011;
    do_reset();
    repeat (2) @(negedge clk);
    chk("R3 ori", int'(upc), 10);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset mid-run", int'(upc), 0);
    rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_seq("R8 lw", 6'b100011, 6, 0, 1, 2, 3, 4, 0);
    t_seq("R8 sw", 6'b101011, 5, 0, 1, 2, 5, 0, 0);
    t_seq("R8 rtype", 6'b000000, 5, 0, 1, 6, 7, 0, 0);
    t_seq("R8 beq", 6'b000100, 4, 0, 1, 8, 0, 0, 0);
    t_seq("R8 jmp", 6'b000010, 4, 0, 1, 9, 0, 0, 0);
    t_seq("R8 ori", 6'b001011, 5, 0, 1, 10, 11, 0, 0);
    t_seq("R5 tab1 miss", 6'b111111, 4, 0, 1, 0, 1, 0, 0);
    t_seq("R2 hold fetch loop", 6'b010101, 3, 0, 1, 0, 0, 0, 0);
    t_tab2_miss();
    t_live_opcode();
    t_mid_reset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule